// File: doc/BRIEF.md
# Path-Qualified MAC Address Lookup Table

This block is a small content-addressable table of 48-bit MAC addresses for a two-port Ethernet switch or relay. Each of its entries holds a full station address, an enable flag and a four-bit mask of the traffic paths on which the entry may be consulted. The four paths are reception on port 0, relay from port 0 to port 1, reception on port 1, and relay from port 1 to port 0. A register-style write port loads addresses, enables, path masks and one global qualifier switch.

A lookup presents a destination address together with a path code. All entries are compared in parallel. One clock later the block returns a single-cycle valid strobe, a hit flag and the index of the winning entry. When the qualifier switch is off, the path masks are ignored and every enabled entry takes part in every lookup. When the switch is on, an entry takes part only on the paths its mask allows. Parsing frames, forwarding, learning and aging are left to the surrounding logic.

Top module: `mac_path_cam`

## Requirements
- R1: After reset, every entry is disabled, every address word is zero, every path-mask bit is zero and the qualifier switch is off. The outputs lk_valid, lk_hit and lk_idx are all zero.
- R2: lk_valid is high for exactly one clock, in the cycle after a cycle with lk_req high. It is never high otherwise.
- R3: An entry hits only when it is enabled and its stored 48-bit address equals lk_addr in every bit. A disabled entry never hits.
- R4: A write with wr_kind=0 stores wr_data[31:0] as address bits 47:16 of entry wr_idx. A write with wr_kind=1 stores wr_data[15:0] as address bits 15:0 of that entry, and bits 31:16 of wr_data are ignored.
- R5: A write with wr_kind=2 sets the enable of entry wr_idx to wr_data[0]. The other bits of wr_data are ignored.
- R6: A write with wr_kind=3 loads path-mask word wr_idx, where word r covers entries 8r to 8r+7. Entry 8r+k takes bits 31-4k down to 28-4k. Inside that nibble, bit 3 is port 0 receive (path code 0), bit 2 is port 0-to-1 relay (code 1), bit 1 is port 1 receive (code 2) and bit 0 is port 1-to-0 relay (code 3). A word number of ENTRIES/8 or above changes nothing.
- R7: A write with wr_kind=4 sets the qualifier switch to wr_data[0]. While the switch is 1, an entry can hit only if its mask bit for lk_path is set.
- R8: While the qualifier switch is 0, the path masks have no effect.
- R9: Any combination of an entry's four mask bits may be set, and the entry then hits on each of those paths.
- R10: When several entries qualify, lk_idx reports the lowest-numbered one. On a miss, lk_hit and lk_idx are both 0.
- R11: A lookup issued in the same cycle as a write sees the table as it was before that write. A lookup issued on the next cycle sees the new contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe |
| wr_kind | input | 3 | Write target: 0 address high, 1 address low, 2 enable, 3 path-mask word, 4 qualifier switch |
| wr_idx | input | IDX_W (5) | Entry number, or mask word number for kind 3 |
| wr_data | input | 32 | Write data |
| lk_req | input | 1 | Lookup request |
| lk_addr | input | 48 | Address to look up |
| lk_path | input | 2 | Path code 0..3 |
| lk_valid | output | 1 | Result strobe, one cycle after lk_req |
| lk_hit | output | 1 | Some entry qualified |
| lk_idx | output | IDX_W (5) | Lowest qualifying entry, 0 on miss |

## Verification
A stored word, enable or mask bit that is corrupted shows up as a wrong hit flag or index on the very next lookup that touches that entry and path. The bench therefore sweeps every entry against every path, both with the qualifier switch off and with it on under a mask pattern that mixes single and multiple bits. A fault in the priority logic only shows when two entries hold the same address, so duplicates are loaded on purpose. A pipeline fault shows up as a result in the wrong cycle, or as a write that is visible too early or too late.

// File: rtl/mpc_pkg.sv
package mpc_pkg;
  localparam int MAC_W       = 48;
  localparam int NIB_PER_WORD = 8;

  typedef enum logic [1:0] {
    PATH_P0_RX    = 2'd0,
    PATH_P0_TO_P1 = 2'd1,
    PATH_P1_RX    = 2'd2,
    PATH_P1_TO_P0 = 2'd3
  } path_e;

  typedef enum logic [2:0] {
    WK_ADDR_HI = 3'd0,
    WK_ADDR_LO = 3'd1,
    WK_ENABLE  = 3'd2,
    WK_MASK    = 3'd3,
    WK_QUAL    = 3'd4
  } wkind_e;
endpackage

// File: rtl/mpc_regs.sv
module mpc_regs
  import mpc_pkg::*;
#(
  parameter int ENTRIES = 32,
  parameter int IDX_W   = $clog2(ENTRIES)
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic                          wr_en,
  input  logic [2:0]                    wr_kind,
  input  logic [IDX_W-1:0]              wr_idx,
  input  logic [31:0]                   wr_data,
  output logic [ENTRIES-1:0][MAC_W-1:0] ent_addr,
  output logic [ENTRIES-1:0]            ent_en,
  output logic [ENTRIES-1:0][3:0]       ent_mask,
  output logic                          qual_en
);
  wkind_e kind;
  assign kind = wkind_e'(wr_kind);

  for (genvar e = 0; e < ENTRIES; e++) begin : g_ent
    localparam int WORD = e / NIB_PER_WORD;
    localparam int TOP  = 31 - 4 * (e % NIB_PER_WORD);
    logic [MAC_W-1:0] addr_q;
    logic             en_q;
    logic [3:0]       mask_q;
    logic             sel_ent;
    logic             sel_word;

    assign sel_ent  = wr_en && (wr_idx == IDX_W'(e));
    assign sel_word = wr_en && (kind == WK_MASK) && (int'(wr_idx) == WORD);

    always_ff @(posedge clk) begin
      if (rst) begin
        addr_q <= '0;
        en_q   <= 1'b0;
      end else if (sel_ent) begin
        case (kind)
          WK_ADDR_HI: addr_q[MAC_W-1:16] <= wr_data;
          WK_ADDR_LO: addr_q[15:0]       <= wr_data[15:0];
          WK_ENABLE:  en_q               <= wr_data[0];
          default: ;
        endcase
      end
    end

    always_ff @(posedge clk) begin
      if (rst) mask_q <= '0;
      else if (sel_word) mask_q <= wr_data[TOP -: 4];
    end

    assign ent_addr[e] = addr_q;
    assign ent_en[e]   = en_q;
    assign ent_mask[e] = mask_q;
  end

  always_ff @(posedge clk) begin
    if (rst) qual_en <= 1'b0;
    else if (wr_en && kind == WK_QUAL) qual_en <= wr_data[0];
  end

  AST_MASK_RESET_ZERO: assert property (@(posedge clk) $past(rst) |-> (ent_mask == '0) && !qual_en); // R1
endmodule

// File: rtl/mpc_match.sv
module mpc_match
  import mpc_pkg::*;
#(
  parameter int ENTRIES = 32
) (
  input  logic [MAC_W-1:0]              lk_addr,
  input  logic [1:0]                    lk_path,
  input  logic [ENTRIES-1:0][MAC_W-1:0] ent_addr,
  input  logic [ENTRIES-1:0]            ent_en,
  input  logic [ENTRIES-1:0][3:0]       ent_mask,
  input  logic                          qual_en,
  output logic [ENTRIES-1:0]            match_vec
);
  // Mask nibble is ordered from path code 0 at bit 3 down to code 3 at bit 0.
  logic [1:0] bit_sel;
  assign bit_sel = ~lk_path;

  for (genvar e = 0; e < ENTRIES; e++) begin : g_cmp
    logic addr_eq;
    logic path_ok;
    assign addr_eq      = (ent_addr[e] == lk_addr);
    assign path_ok      = !qual_en || ent_mask[e][bit_sel];
    assign match_vec[e] = ent_en[e] && addr_eq && path_ok;
  end
endmodule

// File: rtl/mpc_prio.sv
module mpc_prio #(
  parameter int ENTRIES = 32,
  parameter int IDX_W   = $clog2(ENTRIES)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               lk_req,
  input  logic [ENTRIES-1:0] match_vec,
  output logic               lk_valid,
  output logic               lk_hit,
  output logic [IDX_W-1:0]   lk_idx
);
  logic             any_hit;
  logic [IDX_W-1:0] first_idx;

  always_comb begin
    any_hit   = 1'b0;
    first_idx = '0;
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (match_vec[i]) begin
        any_hit   = 1'b1;
        first_idx = IDX_W'(i);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      lk_valid <= 1'b0;
      lk_hit   <= 1'b0;
      lk_idx   <= '0;
    end else begin
      lk_valid <= lk_req;
      if (lk_req) begin
        lk_hit <= any_hit;
        lk_idx <= first_idx;
      end
    end
  end

  AST_VALID_AFTER_REQ: assert property (@(posedge clk) disable iff (rst) lk_req |=> lk_valid); // R2
  AST_NO_SPURIOUS_VALID: assert property (@(posedge clk) disable iff (rst) !lk_req |=> !lk_valid); // R2
  AST_MISS_IDX_ZERO: assert property (@(posedge clk) disable iff (rst) (lk_valid && !lk_hit) |-> (lk_idx == '0)); // R10
  AST_LOWEST_WINS: assert property (@(posedge clk) disable iff (rst)
    (lk_valid && lk_hit) |-> (($past(match_vec) & ((ENTRIES'(1) << lk_idx) - ENTRIES'(1))) == '0)); // R10
endmodule

// File: rtl/mac_path_cam.sv
module mac_path_cam
  import mpc_pkg::*;
#(
  parameter int ENTRIES = 32,
  parameter int IDX_W   = $clog2(ENTRIES)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic [2:0]       wr_kind,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic [31:0]      wr_data,
  input  logic             lk_req,
  input  logic [47:0]      lk_addr,
  input  logic [1:0]       lk_path,
  output logic             lk_valid,
  output logic             lk_hit,
  output logic [IDX_W-1:0] lk_idx
);
  logic [ENTRIES-1:0][MAC_W-1:0] ent_addr;
  logic [ENTRIES-1:0]            ent_en;
  logic [ENTRIES-1:0][3:0]       ent_mask;
  logic                          qual_en;
  logic [ENTRIES-1:0]            match_vec;

  mpc_regs #(.ENTRIES(ENTRIES), .IDX_W(IDX_W)) i_regs (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_kind(wr_kind), .wr_idx(wr_idx),
    .wr_data(wr_data), .ent_addr(ent_addr), .ent_en(ent_en),
    .ent_mask(ent_mask), .qual_en(qual_en)
  );

  mpc_match #(.ENTRIES(ENTRIES)) i_match (
    .lk_addr(lk_addr), .lk_path(lk_path), .ent_addr(ent_addr), .ent_en(ent_en),
    .ent_mask(ent_mask), .qual_en(qual_en), .match_vec(match_vec)
  );

  mpc_prio #(.ENTRIES(ENTRIES), .IDX_W(IDX_W)) i_prio (
    .clk(clk), .rst(rst), .lk_req(lk_req), .match_vec(match_vec),
    .lk_valid(lk_valid), .lk_hit(lk_hit), .lk_idx(lk_idx)
  );

  AST_HIT_ENABLED: assert property (@(posedge clk) disable iff (rst)
    (lk_valid && lk_hit) |-> ((($past(ent_en) >> lk_idx) & ENTRIES'(1)) != '0)); // R3
endmodule

// File: tb/test_mac_path_cam.sv
module test_mac_path_cam;
  localparam int N = 32;
  localparam int IW = 5;

  logic clk = 0, rst = 1;
  logic wr_en = 0;
  logic [2:0] wr_kind = 0;
  logic [IW-1:0] wr_idx = 0;
  logic [31:0] wr_data = 0;
  logic lk_req = 0;
  logic [47:0] lk_addr = 0;
  logic [1:0] lk_path = 0;
  logic lk_valid, lk_hit;
  logic [IW-1:0] lk_idx;

  always #10 clk = ~clk;

  mac_path_cam #(.ENTRIES(N)) i_mac_path_cam (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_kind(wr_kind), .wr_idx(wr_idx),
    .wr_data(wr_data), .lk_req(lk_req), .lk_addr(lk_addr), .lk_path(lk_path),
    .lk_valid(lk_valid), .lk_hit(lk_hit), .lk_idx(lk_idx)
  );

  int checks = 0, fails = 0;
  bit done = 0;

  logic [47:0] m_addr [N];
  bit          m_en   [N];
  logic [3:0]  m_mask [N];
  bit          m_qual;

  function automatic logic [47:0] addr_of(int e);
    logic [31:0] hi = 32'h0A00_0000 + 32'(e) * 32'h0001_0011;
    logic [15:0] lo = 16'h5A00 + 16'(e);
    return {hi, lo};
  endfunction

  function automatic void model(input logic [47:0] a, input logic [1:0] p,
                                output bit h, output int idx);
    h = 0; idx = 0;
    for (int e = N - 1; e >= 0; e--)
      if (m_en[e] && m_addr[e] == a && (!m_qual || m_mask[e][3 - int'(p)])) begin
        h = 1; idx = e;
      end
  endfunction

  task automatic chk(bit ok, string req, string what, longint act, longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic wr(logic [2:0] k, int idx, logic [31:0] d);
    @(negedge clk);
    wr_en = 1; wr_kind = k; wr_idx = IW'(idx); wr_data = d;
    @(negedge clk);
    wr_en = 0;
    case (k)
      3'd0: m_addr[idx][47:16] = d;
      3'd1: m_addr[idx][15:0]  = d[15:0];
      3'd2: m_en[idx]          = d[0];
      3'd3: if (idx < N / 8) for (int k2 = 0; k2 < 8; k2++) m_mask[idx*8+k2] = d[31-4*k2 -: 4];
      3'd4: m_qual = d[0];
      default: ;
    endcase
  endtask

  task automatic look(logic [47:0] a, logic [1:0] p, string req);
    bit h; int ei;
    @(negedge clk);
    lk_req = 1; lk_addr = a; lk_path = p;
    model(a, p, h, ei);
    @(negedge clk);
    lk_req = 0;
    chk(lk_valid && lk_hit == h && int'(lk_idx) == ei, req, "lookup {valid,hit,idx}",
        {lk_valid, lk_hit, lk_idx}, {1'b1, h, IW'(ei)});
  endtask

  task automatic write_masks();
    for (int r = 0; r < N / 8; r++) begin
      logic [31:0] d = 0;
      for (int k = 0; k < 8; k++) d[31-4*k -: 4] = 4'(((r*8+k) * 7 + 3) & 15);
      wr(3'd3, r, d);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    for (int e = 0; e < N; e++) begin m_addr[e] = 0; m_en[e] = 0; m_mask[e] = 0; end
    m_qual = 0;
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    chk({lk_valid, lk_hit, lk_idx} == 0, "R1", "reset outputs", {lk_valid, lk_hit, lk_idx}, 0);
    // R1: all addresses zero but disabled, so address zero misses
    look(48'h0, 2'd0, "R1");
    @(negedge clk);
    chk(!lk_valid, "R2", "valid single cycle", lk_valid, 0);

    // R4: high/low words, upper low-word bits ignored
    for (int e = 0; e < N; e++) begin
      logic [47:0] a = addr_of(e);
      wr(3'd0, e, a[47:16]);
      wr(3'd1, e, {16'hBEEF, a[15:0]});
      wr(3'd2, e, 32'hFFFF_FFFF);  // R5
    end
    chk(!lk_valid, "R2", "no valid on write-only cycles", lk_valid, 0);
    look(addr_of(12), 2'd1, "R4");

    // R1: masks reset to zero, so qualifier on blocks every entry
    wr(3'd4, 0, 32'h1);
    look(addr_of(5), 2'd0, "R1");
    look(addr_of(0), 2'd3, "R7");

    // R8: qualifier off, all entries on all paths
    wr(3'd4, 0, 32'h0);
    for (int e = 0; e < N; e++)
      for (int p = 0; p < 4; p++) look(addr_of(e), 2'(p), "R8");

    // R6 R9: mask pattern, out-of-range word ignored
    write_masks();
    wr(3'd3, 5, 32'hFFFF_FFFF);
    look(addr_of(0), 2'd0, "R8");
    wr(3'd4, 0, 32'h1);
    for (int e = 0; e < N; e++)
      for (int p = 0; p < 4; p++) look(addr_of(e), 2'(p), "R6_R7_R9");
    wr(3'd4, 0, 32'h0);

    // R3: single-bit address differences miss
    look(addr_of(9) ^ 48'h1, 2'd0, "R3");
    look(addr_of(9) ^ 48'h8000_0000_0000, 2'd2, "R3");

    // R5: disable odd entries; bit 1 set with bit 0 clear still disables
    for (int e = 1; e < N; e += 2) wr(3'd2, e, 32'h2);
    for (int e = 0; e < N; e++) look(addr_of(e), 2'd0, "R3_R5");

    // R10: duplicate address, lowest index wins
    wr(3'd0, 20, addr_of(4) >> 16);
    wr(3'd1, 20, {16'h0, addr_of(4) & 16'hFFFF});
    look(addr_of(4), 2'd1, "R10");
    wr(3'd2, 4, 32'h0);
    look(addr_of(4), 2'd1, "R10");
    look(48'hFFFF_FFFF_FFFF, 2'd2, "R10");

    // R11: write and lookup in the same cycle see old contents
    begin
      bit h; int ei;
      @(negedge clk);
      wr_en = 1; wr_kind = 3'd0; wr_idx = IW'(6); wr_data = 32'h1234_5678;
      lk_req = 1; lk_addr = addr_of(6); lk_path = 2'd0;
      model(addr_of(6), 2'd0, h, ei);
      @(negedge clk);
      wr_en = 0; lk_req = 0;
      m_addr[6][47:16] = 32'h1234_5678;
      chk(lk_valid && lk_hit == h && int'(lk_idx) == ei, "R11", "same-cycle old contents",
          {lk_valid, lk_hit, lk_idx}, {1'b1, h, IW'(ei)});
    end
    look(addr_of(6), 2'd0, "R11");
    look({32'h1234_5678, addr_of(6) & 48'hFFFF}, 2'd0, "R11");

    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule